// File: doc/BRIEF.md
# Eight-Register Multicycle Processor Core

This block is a small multicycle processor that runs programs held in a single word-addressed memory. Code and data share that memory. The core keeps a 16-bit program counter and eight 32-bit general registers. Each instruction goes through a fixed sequence of states: the core fetches a word, latches and decodes it, and then executes one of eight operations. The operations are add, bitwise NAND, load, store, branch-if-equal, halt, and two opcodes that do nothing.

The memory sits outside the core and is reached through a plain synchronous port. Read data is valid in the cycle after the address is presented, and a write takes effect at the clock edge where the write enable is high. Programs are placed in that memory before reset is released.

The core stops in one of two ways. A HALT instruction stops it normally. A fetch or load outside the populated memory stops it with a fault. Either way it stays stopped until the next reset. Exactly one of the two status outputs is then high.

Top module: `octreg_core`

## Requirements
- R1: While reset is held and just after it is released, `halted` and `fault` are low, `mem_we` is low, and the first fetch address is 0. All eight registers start at zero.
- R2: An instruction word has the opcode in bits 24:22, register field A in bits 21:19, register field B in bits 18:16, the arithmetic destination in bits 2:0, and an unsigned 16-bit offset in bits 15:0. The opcode values are 0 add, 1 nand, 2 load, 3 store, 4 branch-if-equal, 5 reserved, 6 halt and 7 no-op.
- R3: Add writes regA+regB, wrapped to 32 bits, into the destination register.
- R4: NAND writes ~(regA & regB) into the destination register.
- R5: Load reads the word at (offset + regA) mod 2^16 and writes it into the register named by field B.
- R6: Store writes regB to memory at (offset + regA) mod 2^16.
- R7: A branch whose two registers are equal continues at (PC+1+offset) mod 2^16. Otherwise execution continues at PC+1.
- R8: Halt raises `halted` and leaves `fault` low.
- R9: A fetch from an address at or above MEM_WORDS raises `fault` with `halted` low.
- R10: A load from an address at or above MEM_WORDS raises `fault`, and the core executes nothing further.
- R11: Opcodes 5 and 7 change no register and no memory word, even when their field bits are non-zero.
- R12: Once stopped, the status output stays high until reset, the two status outputs are never high together, and no memory or register write occurs.
- R13: Counted in clock edges from reset release to the stop, every non-load instruction takes 3 cycles and every load takes 4. A bad fetch adds 1 cycle. A faulting load takes 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Word address for fetch, load or store |
| mem_wdata | output | 32 | Store data (regB) |
| mem_we | output | 1 | Store strobe, one cycle per store |
| mem_rdata | input | 32 | Read data, valid one cycle after the address |
| halted | output | 1 | Stopped by a halt instruction |
| fault | output | 1 | Stopped by an out-of-range fetch or load |

## Verification
The bench targets these corner cases:
- Additions that carry out of bit 31. A core that kept the carry would store a wrong sum.
- Effective addresses where regA plus the offset passes 0xFFFF. A core that did not truncate would fault where it should wrap back into memory.
- Branches taken forward, branches taken with a wrapping offset that lands back on an earlier halt, and branches not taken. A core with the wrong base, or without the wrap, would run a skipped store or loop until the watchdog expires.
- The two stop paths. A fetch that runs off the end and a load out of range must each give `fault` without `halted`, at a known cycle count. Nothing may be stored after either stop.
- Reserved and no-op words whose field bits look like an add. These must leave the registers untouched.

// File: rtl/octreg_pkg.sv
`timescale 1ns/1ps
package octreg_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 16;
  localparam int RSEL_W = 3;
  localparam int NREGS  = 1 << RSEL_W;
  localparam int OP_LSB = 22;
  localparam int RA_LSB = 19;
  localparam int RB_LSB = 16;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [RSEL_W-1:0] rsel_t;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_NAND = 3'd1, OP_LOAD = 3'd2, OP_STORE = 3'd3,
    OP_BEQ = 3'd4, OP_RSVD = 3'd5, OP_HALT = 3'd6, OP_NOP = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_LOAD, ST_HALTED, ST_FAULTED
  } state_e;

  typedef struct packed {
    op_e   op;
    rsel_t ra;
    rsel_t rb;
    rsel_t rd;
    addr_t off;
  } fields_t;

  function automatic fields_t split_word(word_t w);
    fields_t f;
    f.op  = op_e'(w[OP_LSB +: 3]);
    f.ra  = w[RA_LSB +: RSEL_W];
    f.rb  = w[RB_LSB +: RSEL_W];
    f.rd  = w[RSEL_W-1:0];
    f.off = w[ADDR_W-1:0];
    return f;
  endfunction

  // 16-bit sum; the carry out of bit 15 is dropped
  function automatic addr_t ea_sum(addr_t off, addr_t base);
    return off + base;
  endfunction

  function automatic word_t nand_word(word_t a, word_t b);
    return ~(a & b);
  endfunction

  function automatic logic in_range(addr_t a, int unsigned words);
    return 32'(a) < words;
  endfunction
endpackage

// File: rtl/octreg_regfile.sv
`timescale 1ns/1ps
module octreg_regfile
  import octreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  rsel_t wsel,
  input  word_t wdata,
  input  rsel_t asel,
  input  rsel_t bsel,
  output word_t adata,
  output word_t bdata
);
  word_t regs [NREGS];

  generate
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
      word_t q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (we && wsel == rsel_t'(g)) q <= wdata;
      end
      assign regs[g] = q;
    end
  endgenerate

  assign adata = regs[asel];
  assign bdata = regs[bsel];
endmodule

// File: rtl/octreg_exec.sv
`timescale 1ns/1ps
module octreg_exec
  import octreg_pkg::*;
#(
  parameter int unsigned MEM_WORDS = 256
) (
  input  word_t   ir,
  input  word_t   a_val,
  input  word_t   b_val,
  input  addr_t   pc_next,
  output fields_t f,
  output word_t   alu_out,
  output addr_t   eff_addr,
  output logic    eff_ok,
  output logic    br_taken,
  output addr_t   br_target
);
  always_comb begin
    f         = split_word(ir);
    alu_out   = (f.op == OP_NAND) ? nand_word(a_val, b_val) : a_val + b_val;
    eff_addr  = ea_sum(f.off, a_val[ADDR_W-1:0]);
    eff_ok    = in_range(eff_addr, MEM_WORDS);
    br_taken  = (f.op == OP_BEQ) && (a_val == b_val);
    br_target = br_taken ? ea_sum(f.off, pc_next) : pc_next;
  end
endmodule

// File: rtl/octreg_ctrl.sv
`timescale 1ns/1ps
module octreg_ctrl
  import octreg_pkg::*;
#(
  parameter int unsigned MEM_WORDS = 256
) (
  input  logic    clk,
  input  logic    rst_n,
  input  word_t   mem_rdata,
  input  fields_t f,
  input  addr_t   eff_addr,
  input  logic    eff_ok,
  input  addr_t   br_target,
  output word_t   ir,
  output addr_t   pc,
  output logic    rf_we,
  output rsel_t   rf_wsel,
  output logic    rf_from_mem,
  output logic    mem_we,
  output addr_t   mem_addr,
  output logic    halted,
  output logic    fault,
  output logic    ev_fetch_bad,
  output logic    ev_load_bad
);
  state_e state;

  always_comb begin
    ev_fetch_bad = (state == ST_FETCH) && !in_range(pc, MEM_WORDS);
    ev_load_bad  = (state == ST_EXEC) && (f.op == OP_LOAD) && !eff_ok;
    rf_from_mem  = (state == ST_LOAD);
    rf_we        = rf_from_mem ||
                   ((state == ST_EXEC) && (f.op == OP_ADD || f.op == OP_NAND));
    rf_wsel      = rf_from_mem ? f.rb : f.rd;
    mem_we       = (state == ST_EXEC) && (f.op == OP_STORE);
    mem_addr     = (state == ST_EXEC) ? eff_addr : pc;
    halted       = (state == ST_HALTED);
    fault        = (state == ST_FAULTED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FETCH;
      pc    <= '0;
      ir    <= '0;
    end else begin
      case (state)
        ST_FETCH:  state <= ev_fetch_bad ? ST_FAULTED : ST_DECODE;
        ST_DECODE: begin
          ir    <= mem_rdata;
          pc    <= pc + addr_t'(1);
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          case (f.op)
            OP_LOAD: state <= eff_ok ? ST_LOAD : ST_FAULTED;
            OP_HALT: state <= ST_HALTED;
            OP_BEQ: begin
              pc    <= br_target;
              state <= ST_FETCH;
            end
            default: state <= ST_FETCH;
          endcase
        end
        ST_LOAD:    state <= ST_FETCH;
        ST_HALTED:  state <= ST_HALTED;
        ST_FAULTED: state <= ST_FAULTED;
        default:    state <= ST_FAULTED;
      endcase
    end
  end
endmodule

// File: rtl/octreg_core.sv
`timescale 1ns/1ps
module octreg_core
  import octreg_pkg::*;
#(
  parameter int unsigned MEM_WORDS = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_we,
  input  logic [31:0] mem_rdata,
  output logic        halted,
  output logic        fault
);
  word_t   ir, a_val, b_val, alu_out, wr_data;
  addr_t   pc, eff_addr, br_target;
  fields_t f;
  logic    eff_ok, br_taken, rf_we, rf_from_mem;
  logic    ev_fetch_bad, ev_load_bad;
  rsel_t   rf_wsel;

  assign wr_data   = rf_from_mem ? mem_rdata : alu_out;
  assign mem_wdata = b_val;

  octreg_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .wsel(rf_wsel), .wdata(wr_data),
    .asel(f.ra), .bsel(f.rb), .adata(a_val), .bdata(b_val)
  );

  octreg_exec #(.MEM_WORDS(MEM_WORDS)) u_exec (
    .ir(ir), .a_val(a_val), .b_val(b_val), .pc_next(pc), .f(f),
    .alu_out(alu_out), .eff_addr(eff_addr), .eff_ok(eff_ok),
    .br_taken(br_taken), .br_target(br_target)
  );

  octreg_ctrl #(.MEM_WORDS(MEM_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .f(f),
    .eff_addr(eff_addr), .eff_ok(eff_ok), .br_target(br_target),
    .ir(ir), .pc(pc), .rf_we(rf_we), .rf_wsel(rf_wsel),
    .rf_from_mem(rf_from_mem), .mem_we(mem_we), .mem_addr(mem_addr),
    .halted(halted), .fault(fault),
    .ev_fetch_bad(ev_fetch_bad), .ev_load_bad(ev_load_bad)
  );
endmodule

// File: rtl/octreg_core_chk.sv
`timescale 1ns/1ps
module octreg_core_chk (
  input logic clk,
  input logic rst_n,
  input logic halted,
  input logic fault,
  input logic mem_we,
  input logic rf_we,
  input logic ev_fetch_bad,
  input logic ev_load_bad
);
  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(halted && fault));                                        // R12
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);                                         // R8
  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);                                           // R12
  AST_STOP_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (halted || fault) |-> !mem_we);                             // R12
  AST_STOP_NO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (halted || fault) |-> !rf_we);                              // R12
  AST_FETCH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch_bad |=> (fault && !halted));                       // R9
  AST_LOAD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load_bad |=> (fault && !rf_we));                         // R10
endmodule

bind octreg_core octreg_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halted(halted), .fault(fault),
  .mem_we(mem_we), .rf_we(rf_we),
  .ev_fetch_bad(ev_fetch_bad), .ev_load_bad(ev_load_bad)
);

// File: tb/octreg_core_bench.sv
`timescale 1ns/1ps
module octreg_core_bench;
  localparam int MEMW = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_we;
  logic [31:0] mem_rdata;
  logic        halted, fault;
  logic [31:0] mem [MEMW];
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  octreg_core #(.MEM_WORDS(MEMW)) u_octreg_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted), .fault(fault)
  );

  always @(posedge clk) begin
    if (mem_we && 32'(mem_addr) < MEMW) mem[mem_addr] <= mem_wdata;
    mem_rdata <= (32'(mem_addr) < MEMW) ? mem[mem_addr] : 32'h0;
  end

  function automatic logic [31:0] enc(int op, int a, int b, int off);
    return {7'd0, 3'(op), 3'(a), 3'(b), 16'(off)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic boot();
    rst_n = 1'b0;
    for (int i = 0; i < MEMW; i++) mem[i] = 32'h0;
  endtask

  task automatic release_run(output int cyc);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    cyc = 0;
    do begin
      @(posedge clk);
      cyc++;
      #1;
    end while (!(halted || fault) && cyc < 5000);
  endtask

  task automatic hold_quiet(string tag, logic want_halt);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk({tag, " status halted"}, 32'(halted), 32'(want_halt));
      chk({tag, " status fault"}, 32'(fault), 32'(!want_halt));
      chk({tag, " no store"}, 32'(mem_we), 32'h0);
    end
  endtask

  // R1 reset state, zeroed registers; R8 halt; R13 timing
  task automatic t_reset();
    int cyc;
    boot();
    mem[0]   = enc(3, 0, 3, 100);
    mem[1]   = enc(6, 0, 0, 0);
    mem[100] = 32'h12345678;
    repeat (2) @(negedge clk);
    chk("R1 halted in reset", 32'(halted), 32'h0);
    chk("R1 fault in reset", 32'(fault), 32'h0);
    chk("R1 we in reset", 32'(mem_we), 32'h0);
    chk("R1 first fetch address", 32'(mem_addr), 32'h0);
    release_run(cyc);
    chk("R1 register zero after reset", mem[100], 32'h0);
    chk("R8 halted", 32'(halted), 32'h1);
    chk("R13 cycles store+halt", 32'(cyc), 32'd6);
    hold_quiet("R12 after halt", 1'b1);
  endtask

  // R2 fields, R3 add wrap, R4 nand, R5 load into B register, R6 store
  task automatic t_alu();
    int cyc;
    boot();
    mem[0]  = enc(2, 0, 1, 50);
    mem[1]  = enc(2, 0, 2, 51);
    mem[2]  = enc(0, 1, 2, 3);
    mem[3]  = enc(1, 1, 2, 4);
    mem[4]  = enc(3, 0, 3, 60);
    mem[5]  = enc(3, 0, 4, 61);
    mem[6]  = enc(6, 0, 0, 0);
    mem[50] = 32'hFFFFFFF0;
    mem[51] = 32'h00000025;
    release_run(cyc);
    chk("R3 add wraps at 32 bits", mem[60], 32'h00000015);
    chk("R4 nand", mem[61], ~(32'hFFFFFFF0 & 32'h00000025));
    chk("R2 R6 loaded value stored", mem[51], 32'h00000025);
    chk("R13 cycles two loads", 32'(cyc), 32'd23);
    chk("R8 halt not fault", 32'(fault), 32'h0);
  endtask

  // R5 R6 effective address wraps at 16 bits
  task automatic t_ea_wrap();
    int cyc;
    boot();
    mem[0]   = enc(2, 0, 1, 52);
    mem[1]   = enc(2, 1, 2, 16'h0105);
    mem[2]   = enc(3, 0, 2, 62);
    mem[3]   = enc(3, 1, 2, 16'h0106);
    mem[4]   = enc(6, 0, 0, 0);
    mem[52]  = 32'h0001FFF0;
    mem[245] = 32'hCAFE1234;
    release_run(cyc);
    chk("R5 wrapped load address", mem[62], 32'hCAFE1234);
    chk("R6 wrapped store address", mem[246], 32'hCAFE1234);
    chk("R10 no fault on wrapped load", 32'(fault), 32'h0);
  endtask

  // R7 branch taken, not taken, wrapped target
  task automatic t_branch();
    int cyc;
    boot();
    mem[0]  = enc(2, 0, 1, 50);
    mem[1]  = enc(2, 0, 2, 51);
    mem[2]  = enc(4, 1, 2, 2);
    mem[3]  = enc(3, 0, 1, 70);
    mem[4]  = enc(6, 0, 0, 0);
    mem[5]  = enc(4, 1, 0, 1);
    mem[6]  = enc(3, 0, 2, 71);
    mem[7]  = enc(4, 0, 0, 16'hFFFC);
    mem[50] = 32'd7;
    mem[51] = 32'd7;
    mem[70] = 32'h0000AAAA;
    release_run(cyc);
    chk("R7 taken branch skips store", mem[70], 32'h0000AAAA);
    chk("R7 untaken branch falls through", mem[71], 32'd7);
    chk("R7 wrapped target reaches halt", 32'(halted), 32'h1);
    chk("R13 cycles branch program", 32'(cyc), 32'd23);
  endtask

  // R11 reserved and no-op words change nothing
  task automatic t_reserved();
    int cyc;
    boot();
    mem[0]  = enc(2, 0, 1, 50);
    mem[1]  = enc(5, 1, 1, 1);
    mem[2]  = enc(7, 1, 1, 1);
    mem[3]  = enc(3, 0, 1, 72);
    mem[4]  = enc(6, 0, 0, 0);
    mem[50] = 32'd9;
    release_run(cyc);
    chk("R11 opcode 5 and 7 leave register", mem[72], 32'd9);
    chk("R13 cycles with no-ops", 32'(cyc), 32'd16);
  endtask

  // R9 fetch past end of memory
  task automatic t_fetch_fault();
    int cyc;
    boot();
    mem[0] = enc(7, 0, 0, 0);
    mem[1] = enc(4, 0, 0, 16'h00FE);
    release_run(cyc);
    chk("R9 fault on fetch", 32'(fault), 32'h1);
    chk("R9 halted low", 32'(halted), 32'h0);
    chk("R13 cycles bad fetch", 32'(cyc), 32'd7);
    hold_quiet("R12 after fetch fault", 1'b0);
  endtask

  // R10 load out of range
  task automatic t_load_fault();
    int cyc;
    boot();
    mem[0]  = enc(2, 0, 1, 50);
    mem[1]  = enc(2, 0, 1, 300);
    mem[2]  = enc(3, 0, 1, 73);
    mem[3]  = enc(6, 0, 0, 0);
    mem[50] = 32'h11;
    mem[73] = 32'h0000BEEF;
    release_run(cyc);
    chk("R10 fault on load", 32'(fault), 32'h1);
    chk("R10 halted low", 32'(halted), 32'h0);
    chk("R10 later store not run", mem[73], 32'h0000BEEF);
    chk("R13 cycles faulting load", 32'(cyc), 32'd7);
    hold_quiet("R12 after load fault", 1'b0);
  endtask

  initial begin
    t_reset();
    t_alu();
    t_ea_wrap();
    t_branch();
    t_reserved();
    t_fetch_fault();
    t_load_fault();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule